// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit decides whether a jump-class instruction transfers control and produces the program counter of the next instruction. The program counter counts 64-bit instruction slots, and every displacement is measured from the slot that follows the branch. The unit is given the current PC, a 4-bit jump code, the operand-source bit, a class flag, the destination operand, the source register value, the 32-bit immediate, the 16-bit offset and the call-kind field. The class flag selects a 64-bit compare or a compare on the low 32 bits only.

Each accepted request produces one registered result one clock later. The result carries a taken flag, the next PC and three side flags: call, exit and illegal. Logic around the unit uses the side flags to run helper calls, returns and traps. The unit itself holds no call stack and performs no fetch.

Top module: `bru_resolve`

## Requirements
- R1: Code 0x1 is taken when the two operands are equal, and code 0x5 when they differ. Code 0x4 is taken when the bitwise AND of the two operands is nonzero.
- R2: Codes 0x2 (greater), 0x3 (greater or equal), 0xa (less) and 0xb (less or equal) compare the operands as unsigned numbers.
- R3: Codes 0x6 (greater), 0x7 (greater or equal), 0xc (less) and 0xd (less or equal) compare the operands as two's-complement signed numbers.
- R4: When `in_wide` is 0, only bits 31:0 of both operands take part in the compare. When `in_src_sel` is 0, the right operand is the immediate sign-extended to 64 bits. When `in_src_sel` is 1, the right operand is `in_src`.
- R5: A taken conditional branch gives next PC = PC + 1 + the sign-extended 16-bit offset, modulo 2^32.
- R6: When the branch is not taken (a false condition, a helper call, an exit or an illegal request), next PC = PC + 1, modulo 2^32.
- R7: Code 0x0 with `in_src_sel` = 0 is always taken. Its displacement is the signed offset when `in_wide` = 1 and the signed 32-bit immediate when `in_wide` = 0.
- R8: Code 0x8 with `in_src_sel` = 0 raises `out_call`. With call kind 1 it is taken to PC + 1 + the signed immediate. With any other call kind it is not taken.
- R9: Code 0x9 with `in_src_sel` = 0 raises `out_exit` and is not taken.
- R10: Codes 0xe and 0xf, and codes 0x0, 0x8 and 0x9 with `in_src_sel` = 1, raise `out_illegal` with taken, call and exit all at 0. At most one of call, exit and illegal is ever set.
- R11: Outputs register one cycle after `in_valid`. `out_valid` follows `in_valid` with one cycle of delay. While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_pc | input | 32 | Current PC in instruction slots |
| in_code | input | 4 | Jump code |
| in_src_sel | input | 1 | 1: register source, 0: immediate source |
| in_wide | input | 1 | 1: 64-bit class, 0: 32-bit class |
| in_dst | input | 64 | Destination operand (left side) |
| in_src | input | 64 | Source register value |
| in_imm | input | 32 | Signed immediate |
| in_off | input | 16 | Signed offset |
| in_call_kind | input | 4 | Call kind field (1 = program-local) |
| out_valid | output | 1 | Result strobe |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 32 | Next PC |
| out_call | output | 1 | Call code accepted |
| out_exit | output | 1 | Exit code accepted |
| out_illegal | output | 1 | Unsupported encoding |

## Verification
A wrong internal state in this unit appears at the ports in the cycle after the request. A bad compare, for example a sign bit taken from the wrong lane, flips `out_taken` and moves `out_next_pc` away from PC + 1. A wrong displacement choice leaves `out_taken` correct but puts `out_next_pc` at a target off by the difference between the offset and the immediate. The sweep runs every code, both classes and both source kinds over operands placed at the sign and width boundaries. Each mismatch is therefore seen on the first cycle it can occur.

// File: rtl/bru_pkg.sv
package bru_pkg;
   typedef enum logic [3:0] {
      JC_ALWAYS = 4'h0,
      JC_EQ     = 4'h1,
      JC_UGT    = 4'h2,
      JC_UGE    = 4'h3,
      JC_ANY    = 4'h4,
      JC_NE     = 4'h5,
      JC_SGT    = 4'h6,
      JC_SGE    = 4'h7,
      JC_CALL   = 4'h8,
      JC_RET    = 4'h9,
      JC_ULT    = 4'ha,
      JC_ULE    = 4'hb,
      JC_SLT    = 4'hc,
      JC_SLE    = 4'hd
   } jcode_e;

   localparam logic [3:0] LOCAL_CALL_KIND = 4'h1;

   typedef struct packed {
      logic taken;
      logic call;
      logic ret;
      logic bad;
   } verdict_t;
endpackage

// File: rtl/bru_cmp.sv
module bru_cmp
   import bru_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int NARROW_W  = 32,
   parameter bit SUB_BASED = 1'b1
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   input  logic              narrow,
   input  logic [3:0]        code,
   output logic              hit
);
   logic [DATA_W-1:0] ua, ub, sa, sb;
   logic eq, ult, slt;

   always_comb begin
      ua = narrow ? DATA_W'(lhs[NARROW_W-1:0]) : lhs;
      ub = narrow ? DATA_W'(rhs[NARROW_W-1:0]) : rhs;
      sa = narrow ? DATA_W'(signed'(lhs[NARROW_W-1:0])) : lhs;
      sb = narrow ? DATA_W'(signed'(rhs[NARROW_W-1:0])) : rhs;
   end

   assign eq = (ua == ub);

   generate
      if (SUB_BASED) begin : g_sub
         logic [DATA_W:0] udiff, sdiff;
         assign udiff = {1'b0, ua} - {1'b0, ub};
         assign sdiff = {1'b0, sa} - {1'b0, sb};
         assign ult   = udiff[DATA_W];
         assign slt   = (sa[DATA_W-1] != sb[DATA_W-1]) ? sa[DATA_W-1] : sdiff[DATA_W];
      end else begin : g_native
         assign ult = (ua < ub);
         assign slt = ($signed(sa) < $signed(sb));
      end
   endgenerate

   always_comb begin
      case (code)
         JC_EQ:   hit = eq;
         JC_NE:   hit = !eq;
         JC_ANY:  hit = |(ua & ub);
         JC_UGT:  hit = !ult && !eq;
         JC_UGE:  hit = !ult;
         JC_ULT:  hit = ult;
         JC_ULE:  hit = ult || eq;
         JC_SGT:  hit = !slt && !eq;
         JC_SGE:  hit = !slt;
         JC_SLT:  hit = slt;
         JC_SLE:  hit = slt || eq;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/bru_target.sv
module bru_target #(
   parameter int PC_W = 32
) (
   input  logic [PC_W-1:0] pc,
   input  logic [PC_W-1:0] disp,
   output logic [PC_W-1:0] seq_pc,
   output logic [PC_W-1:0] jump_pc
);
   assign seq_pc  = pc + PC_W'(1);
   assign jump_pc = seq_pc + disp;
endmodule

// File: rtl/bru_resolve.sv
module bru_resolve
   import bru_pkg::*;
#(
   parameter int PC_W      = 32,
   parameter int DATA_W    = 64,
   parameter int NARROW_W  = 32,
   parameter int IMM_W     = 32,
   parameter int OFF_W     = 16,
   parameter bit SUB_BASED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [PC_W-1:0]   in_pc,
   input  logic [3:0]        in_code,
   input  logic              in_src_sel,
   input  logic              in_wide,
   input  logic [DATA_W-1:0] in_dst,
   input  logic [DATA_W-1:0] in_src,
   input  logic [IMM_W-1:0]  in_imm,
   input  logic [OFF_W-1:0]  in_off,
   input  logic [3:0]        in_call_kind,
   output logic              out_valid,
   output logic              out_taken,
   output logic [PC_W-1:0]   out_next_pc,
   output logic              out_call,
   output logic              out_exit,
   output logic              out_illegal
);
   initial begin
      if (NARROW_W > DATA_W) $error("bru_resolve: NARROW_W exceeds DATA_W");
      if (IMM_W > DATA_W)    $error("bru_resolve: IMM_W exceeds DATA_W");
      if (OFF_W > PC_W)      $error("bru_resolve: OFF_W exceeds PC_W");
      if (IMM_W > PC_W)      $error("bru_resolve: IMM_W exceeds PC_W");
   end

   logic [DATA_W-1:0] rhs;
   logic              cond_hit;
   logic [PC_W-1:0]   disp, seq_pc, jump_pc, nxt_pc;
   logic [PC_W-1:0]   off_ext, imm_ext;
   verdict_t          v;

   assign rhs     = in_src_sel ? in_src : DATA_W'(signed'(in_imm));
   assign off_ext = PC_W'(signed'(in_off));
   assign imm_ext = PC_W'(signed'(in_imm));

   bru_cmp #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W),
      .SUB_BASED(SUB_BASED)
   ) cmp_i (
      .lhs   (in_dst),
      .rhs   (rhs),
      .narrow(!in_wide),
      .code  (in_code),
      .hit   (cond_hit)
   );

   always_comb begin
      v    = '0;
      disp = off_ext;
      case (in_code)
         JC_ALWAYS: begin
            if (in_src_sel) v.bad = 1'b1;
            else begin
               v.taken = 1'b1;
               disp    = in_wide ? off_ext : imm_ext;
            end
         end
         JC_CALL: begin
            if (in_src_sel) v.bad = 1'b1;
            else begin
               v.call  = 1'b1;
               v.taken = (in_call_kind == LOCAL_CALL_KIND);
               disp    = imm_ext;
            end
         end
         JC_RET: begin
            if (in_src_sel) v.bad = 1'b1;
            else            v.ret = 1'b1;
         end
         JC_EQ, JC_NE, JC_ANY, JC_UGT, JC_UGE, JC_ULT, JC_ULE,
         JC_SGT, JC_SGE, JC_SLT, JC_SLE: v.taken = cond_hit;
         default: v.bad = 1'b1;
      endcase
   end

   bru_target #(.PC_W(PC_W)) tgt_i (
      .pc     (in_pc),
      .disp   (disp),
      .seq_pc (seq_pc),
      .jump_pc(jump_pc)
   );

   assign nxt_pc = v.taken ? jump_pc : seq_pc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_taken   <= 1'b0;
         out_next_pc <= '0;
         out_call    <= 1'b0;
         out_exit    <= 1'b0;
         out_illegal <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_taken   <= v.taken;
            out_next_pc <= nxt_pc;
            out_call    <= v.call;
            out_exit    <= v.ret;
            out_illegal <= v.bad;
         end
      end
   end
endmodule

// File: rtl/bru_resolve_chk.sv
module bru_resolve_chk #(
   parameter int PC_W   = 32,
   parameter int DATA_W = 64,
   parameter int IMM_W  = 32,
   parameter int OFF_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [PC_W-1:0]   in_pc,
   input logic [3:0]        in_code,
   input logic              in_src_sel,
   input logic              in_wide,
   input logic [DATA_W-1:0] in_dst,
   input logic [DATA_W-1:0] in_src,
   input logic [IMM_W-1:0]  in_imm,
   input logic [OFF_W-1:0]  in_off,
   input logic [3:0]        in_call_kind,
   input logic              out_valid,
   input logic              out_taken,
   input logic [PC_W-1:0]   out_next_pc,
   input logic              out_call,
   input logic              out_exit,
   input logic              out_illegal
);
   // R11
   valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n && $past(rst_n) |-> out_valid == $past(in_valid));

   // R6
   seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && out_valid && !out_taken |-> out_next_pc == $past(in_pc) + PC_W'(1));

   // R10
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({out_call, out_exit, out_illegal}));

   // R10
   illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_illegal |-> !out_taken);

   // R9
   exit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_exit |-> !out_taken);

   // R7
   ja_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_code == 4'h0 && !in_src_sel |=> out_taken);
endmodule

bind bru_resolve bru_resolve_chk #(
   .PC_W  (PC_W),
   .DATA_W(DATA_W),
   .IMM_W (IMM_W),
   .OFF_W (OFF_W)
) chk_i (.*);

// File: tb/bru_resolve_tb_top.sv
module bru_resolve_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [31:0] in_pc;
   logic [3:0]  in_code;
   logic        in_src_sel;
   logic        in_wide;
   logic [63:0] in_dst;
   logic [63:0] in_src;
   logic [31:0] in_imm;
   logic [15:0] in_off;
   logic [3:0]  in_call_kind;
   logic        out_valid, out_taken, out_call, out_exit, out_illegal;
   logic [31:0] out_next_pc;

   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   bru_resolve dut_i (.*);

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   function automatic logic [63:0] opv(input int i);
      case (i)
         0: opv = 64'h0;
         1: opv = 64'h1;
         2: opv = 64'h0000_0000_FFFF_FFFF;
         3: opv = 64'h0000_0000_8000_0000;
         4: opv = 64'h7FFF_FFFF_FFFF_FFFF;
         5: opv = 64'h8000_0000_0000_0000;
         6: opv = 64'hFFFF_FFFF_FFFF_FFFF;
         default: opv = 64'h0000_0001_0000_0005;
      endcase
   endfunction

   function automatic logic [15:0] offv(input int i);
      case (i)
         0: offv = 16'hFFFF;
         1: offv = 16'h0005;
         2: offv = 16'h7FFF;
         default: offv = 16'h8000;
      endcase
   endfunction

   function automatic logic [31:0] pcv(input int i);
      case (i)
         0: pcv = 32'h0;
         1: pcv = 32'h100;
         2: pcv = 32'hFFFF_FFFF;
         default: pcv = 32'h7FFF_FFF0;
      endcase
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic one(input int code, input bit ss, input bit wd, input int ai, input int bi);
      logic [63:0] a, sv, b, ua, ub;
      logic signed [63:0] sa, sb;
      logic [31:0] imm, pc, disp, epc;
      logic [15:0] off;
      logic [3:0] ck;
      bit cond, et, ec, ee, ei;
      string tag, ptag;
      a   = opv(ai);
      sv  = opv(bi);
      imm = sv[31:0] ^ (ai[0] ? 32'h0 : 32'h8000_0000);
      off = offv((ai * 3 + bi) % 4);
      pc  = pcv((ai + 2 * bi) % 4);
      ck  = 4'((ai + bi) % 3);
      b   = ss ? sv : {{32{imm[31]}}, imm};
      ua  = wd ? a : {32'h0, a[31:0]};
      ub  = wd ? b : {32'h0, b[31:0]};
      sa  = wd ? $signed(a) : $signed({{32{a[31]}}, a[31:0]});
      sb  = wd ? $signed(b) : $signed({{32{b[31]}}, b[31:0]});
      cond = 0; et = 0; ec = 0; ee = 0; ei = 0;
      disp = {{16{off[15]}}, off};
      tag = "R1"; ptag = "R5";
      case (code)
         1:  begin cond = (ua == ub);    tag = "R1"; end
         5:  begin cond = (ua != ub);    tag = "R1"; end
         4:  begin cond = |(ua & ub);    tag = "R1"; end
         2:  begin cond = ua > ub;       tag = "R2"; end
         3:  begin cond = ua >= ub;      tag = "R2"; end
         10: begin cond = ua < ub;       tag = "R2"; end
         11: begin cond = ua <= ub;      tag = "R2"; end
         6:  begin cond = sa > sb;       tag = "R3"; end
         7:  begin cond = sa >= sb;      tag = "R3"; end
         12: begin cond = sa < sb;       tag = "R3"; end
         13: begin cond = sa <= sb;      tag = "R3"; end
         default: ;
      endcase
      if (code == 0 || code == 8 || code == 9) begin
         if (ss) begin ei = 1; tag = "R10"; end
         else if (code == 0) begin
            et = 1; tag = "R7"; ptag = "R7";
            if (!wd) disp = imm;
         end else if (code == 8) begin
            ec = 1; et = (ck == 4'h1); disp = imm; tag = "R8"; ptag = "R8";
         end else begin ee = 1; tag = "R9"; end
      end else if (code >= 14) begin
         ei = 1; tag = "R10";
      end else begin
         et = cond;
         if (!wd) tag = "R4";
      end
      epc = et ? pc + 32'd1 + disp : pc + 32'd1;
      if (!et) ptag = "R6";
      @(negedge clk);
      in_valid = 1; in_code = 4'(code); in_src_sel = ss; in_wide = wd;
      in_dst = a; in_src = sv; in_imm = imm; in_off = off; in_pc = pc; in_call_kind = ck;
      @(negedge clk);
      in_valid = 0;
      check({out_taken, out_call, out_exit, out_illegal} == {et, ec, ee, ei}, tag, "flags",
            {60'h0, out_taken, out_call, out_exit, out_illegal}, {60'h0, et, ec, ee, ei});
      check(out_next_pc == epc, ptag, "next_pc", {32'h0, out_next_pc}, {32'h0, epc});
      check(out_valid == 1'b1, "R11", "valid", {63'h0, out_valid}, 64'h1);
   endtask

   initial begin
      rst_n = 0; in_valid = 0; in_pc = 0; in_code = 0; in_src_sel = 0; in_wide = 0;
      in_dst = 0; in_src = 0; in_imm = 0; in_off = 0; in_call_kind = 0;
      repeat (3) @(negedge clk);
      // R11: reset state
      check({out_valid, out_taken, out_call, out_exit, out_illegal} == 5'b0 && out_next_pc == 0,
            "R11", "reset", {27'h0, out_next_pc, out_valid, out_taken, out_call, out_exit, out_illegal}, 64'h0);
      rst_n = 1;
      @(negedge clk);
      check(out_valid == 1'b0, "R11", "idle valid", {63'h0, out_valid}, 64'h0);
      for (int c = 0; c < 16; c++)
         for (int s = 0; s < 2; s++)
            for (int w = 0; w < 2; w++)
               for (int ai = 0; ai < 8; ai++)
                  for (int bi = 0; bi < 8; bi++)
                     one(c, s[0], w[0], ai, bi);
      @(negedge clk);
      // R11: valid drops one cycle after in_valid drops
      check(out_valid == 1'b0, "R11", "valid drop", {63'h0, out_valid}, 64'h0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule